// File: doc/BRIEF.md
# Machine Clock Gear Divider

This block turns the free-running source oscillator clock into a machine-clock enable. The enable is a one-source-cycle pulse that marks the start of each machine cycle. A two-bit gear value picks the divide ratio. The downstream logic advances only on source edges where the enable is high, so no divided clock is ever built and nothing can glitch.

Software changes the speed by writing a new gear value. A write restarts the divider, so the next machine cycle runs at the new rate. When the written gear is a divided one, that cycle is held back by a fixed number of extra source periods. The gear value survives the external and software resets and returns to full speed only on power-on reset. The current gear is always visible on a readback port.

Top module: `gear_clk_div`

## Requirements
- R1: After power-on reset (rst_ni low) gear_o reads 2'b11 and mce_o is high on every source cycle.
- R2: Gear encodings set the machine cycle length in source cycles: 2'b11 is 1, 2'b10 is 2, 2'b01 is 4 and 2'b00 is 16. In steady state mce_o pulses once per machine cycle.
- R3: A source cycle with wr_i high loads wr_data_i into the gear, and gear_o shows it from the following cycle.
- R4: A write restarts the divider phase. After the stretch, pulses follow at the new ratio, whatever the old phase or gear.
- R5: When the written value is not 2'b11, the next pulse comes 4 source cycles after the write edge instead of immediately. When the written value is 2'b11, a pulse comes on the first cycle after the write edge.
- R6: A write that arrives while a stretch is still running starts the stretch again from the new write.
- R7: While ext_rst_i is high, mce_o is low and the gear is unchanged. The first cycle after release carries a pulse, and the old gear ratio follows.
- R8: sw_rst_i behaves exactly like ext_rst_i: it leaves the gear unchanged, holds mce_o low and restarts the phase on release.
- R9: With a divided gear, mce_o is never high on two consecutive cycles unless a reset release or a write intervenes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_i | input | 1 | External reset, synchronous, restarts divider only |
| sw_rst_i | input | 1 | Software reset, synchronous, restarts divider only |
| wr_i | input | 1 | Gear register write strobe |
| wr_data_i | input | 2 | Gear value to write |
| gear_o | output | 2 | Current gear readback |
| mce_o | output | 1 | Machine-clock enable pulse |

## Verification
The assertions assume that ext_rst_i, sw_rst_i, wr_i and wr_data_i change only between clock edges and are stable around each rising edge. They also assume that rst_ni is held low for at least one edge before any other input is relied upon. The bench changes every input on the falling edge and samples outputs there too, so each write or reset takes effect at one known rising edge. From that edge the bench counts source cycles and works out where each pulse must fall, using the divide ratio, the stretch length and the modulo arithmetic.

// File: rtl/gear_pkg.sv
package gear_pkg;
  localparam int unsigned GEAR_W = 2;
  typedef logic [GEAR_W-1:0] gear_t;
  localparam gear_t GEAR_FULL = 2'b11;
  localparam gear_t GEAR_DIV2 = 2'b10;
  localparam gear_t GEAR_DIV4 = 2'b01;
  localparam gear_t GEAR_SLOW = 2'b00;
endpackage

// File: rtl/gear_reg.sv
module gear_reg
  import gear_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  gear_t wr_data_i,
  output gear_t gear_o
);
  // only power-on reset touches the gear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   gear_o <= GEAR_FULL;
    else if (wr_i) gear_o <= wr_data_i;
  end

  assert_write_loads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> gear_o == $past(wr_data_i));
  assert_gear_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(gear_o));
endmodule

// File: rtl/gear_divider.sv
module gear_divider
  import gear_pkg::*;
#(
  parameter int unsigned SLOW_DIV    = 16,
  parameter int unsigned STRETCH_CYC = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rst_any_i,
  input  logic  wr_i,
  input  gear_t wr_data_i,
  input  gear_t gear_i,
  output logic  mce_o
);
  localparam int unsigned CW = $clog2(SLOW_DIV);
  localparam int unsigned SW = $clog2(STRETCH_CYC + 1);

  logic [CW-1:0] cnt_q, last;
  logic [SW-1:0] str_q;

  always_comb begin
    unique case (gear_i)
      GEAR_FULL: last = '0;
      GEAR_DIV2: last = CW'(1);
      GEAR_DIV4: last = CW'(3);
      default:   last = CW'(SLOW_DIV - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      str_q <= '0;
    end else if (rst_any_i) begin
      cnt_q <= '0;
      str_q <= '0;
    end else if (wr_i) begin
      // restart phase; divided targets get the stretch (re-armed if running)
      cnt_q <= '0;
      str_q <= (wr_data_i == GEAR_FULL) ? '0 : SW'(STRETCH_CYC);
    end else if (str_q != '0) begin
      str_q <= str_q - 1'b1;
    end else if (cnt_q == last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mce_o = (cnt_q == '0) && (str_q == '0) && !rst_any_i;

  assert_full_speed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gear_i == GEAR_FULL && !rst_any_i) |-> mce_o);
  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mce_o && gear_i != GEAR_FULL && !wr_i && !rst_any_i) |=> !mce_o);
endmodule

// File: rtl/gear_clk_div.sv
module gear_clk_div
  import gear_pkg::*;
#(
  parameter int unsigned SLOW_DIV    = 16,
  parameter int unsigned STRETCH_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_i,
  input  logic       sw_rst_i,
  input  logic       wr_i,
  input  logic [1:0] wr_data_i,
  output logic [1:0] gear_o,
  output logic       mce_o
);
  logic  rst_any;
  gear_t gear_q;

  assign rst_any = ext_rst_i | sw_rst_i;

  gear_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .wr_data_i(gear_t'(wr_data_i)),
    .gear_o   (gear_q)
  );

  gear_divider #(
    .SLOW_DIV   (SLOW_DIV),
    .STRETCH_CYC(STRETCH_CYC)
  ) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rst_any_i(rst_any),
    .wr_i     (wr_i),
    .wr_data_i(gear_t'(wr_data_i)),
    .gear_i   (gear_q),
    .mce_o    (mce_o)
  );

  assign gear_o = gear_q;

  assert_stretch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rst_any && wr_data_i != GEAR_FULL) |=> !mce_o);
  assert_reset_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_any |-> !mce_o);
  assert_release_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_any) && !rst_any) |-> mce_o);
endmodule

// File: tb/sim_gear_clk_div.sv
`timescale 1ns/1ps
module sim_gear_clk_div;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_rst_i = 1'b0;
  logic       sw_rst_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [1:0] wr_data_i = 2'b11;
  logic [1:0] gear_o;
  logic       mce_o;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  gear_clk_div u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_i(ext_rst_i), .sw_rst_i(sw_rst_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .gear_o(gear_o), .mce_o(mce_o)
  );

  function automatic int div_of(input logic [1:0] g);
    case (g)
      2'b11:   return 1;
      2'b10:   return 2;
      2'b01:   return 4;
      default: return 16;
    endcase
  endfunction

  function automatic bit pulse_exp(input int k, input int s, input int n);
    return (k >= s) && (((k - s) % n) == 0);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // write at the coming edge; check len cycles of pulse pattern afterwards
  task automatic do_write(input logic [1:0] d, input int len, input string req);
    int n, s;
    n = div_of(d);
    s = (d == 2'b11) ? 0 : 4;
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_i = 1'b0;
    #0.1;
    chk(req, gear_o, d);
    for (int k = 0; k < len; k++) begin
      if (k > 0) begin @(negedge clk); #0.1; end
      chk(req, mce_o, pulse_exp(k, s, n));
    end
  endtask

  task automatic do_reset(input bit use_sw, input string req);
    logic [1:0] g;
    int n;
    g = gear_o;
    n = div_of(g);
    if (use_sw) sw_rst_i = 1'b1; else ext_rst_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #0.1;
      chk(req, mce_o, 0);
      chk(req, gear_o, g);
    end
    @(negedge clk);
    sw_rst_i = 1'b0; ext_rst_i = 1'b0;
    #0.1;
    for (int j = 0; j < 2 * n + 2; j++) begin
      if (j > 0) begin @(negedge clk); #0.1; end
      chk(req, mce_o, (j % n) == 0);
    end
    chk(req, gear_o, g);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: power-on state
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #0.1;
      chk("R1", gear_o, 2'b11);
      chk("R1", mce_o, 1);
    end
    // R2 R3 R4 R5: every old/new gear pair, several phases of old gear
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int ph = 0; ph < 3; ph++) begin
          do_write(2'(a), 20, "R3");
          repeat (ph) @(negedge clk);
          do_write(2'(b), 40, (b == 3) ? "R5" : "R4");
        end
    // R2: long steady run at slowest gear
    do_write(2'b00, 70, "R2");
    // R6: rewrite while stretch still running
    for (int a = 0; a < 3; a++)
      for (int m = 1; m < 4; m++)
        for (int b = 0; b < 4; b++) begin
          do_write(2'(a), m, "R6");
          do_write(2'(b), 40, "R6");
        end
    // R7 R8: resets keep gear, restart phase
    for (int g = 0; g < 4; g++) begin
      do_write(2'(g), 7, "R7");
      do_reset(1'b0, "R7");
      do_write(2'(g), 5, "R8");
      do_reset(1'b1, "R8");
    end
    // R9: divided gears never pulse back to back
    for (int g = 0; g < 3; g++) begin
      int prev;
      do_write(2'(g), 5, "R9");
      prev = mce_o;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); #0.1;
        chk("R9", prev & mce_o, 0);
        prev = mce_o;
      end
    end
    // R1: power-on reset restores full speed
    do_write(2'b00, 3, "R1");
    rst_ni = 1'b0;
    @(negedge clk); #0.1;
    chk("R1", gear_o, 2'b11);
    rst_ni = 1'b1;
    @(negedge clk); #0.1;
    chk("R1", mce_o, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule